// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache Controller

This controller places four one-byte lines between a processor-side request port and a slow byte-wide backing memory covering a 16-byte space. Address bits [1:0] select the line and bits [3:2] form the tag. Each line holds a byte of data, a 3-bit stored tag and three one-bit state flags: invalid, modified and shared. Processor writes go only into the cache, and the line is marked modified. Memory is updated only when a modified line is evicted.

A request is made by raising `cpu_req` with `cpu_we`, `cpu_addr` and `cpu_wdata`, and holding them until `cpu_ready` pulses for one cycle. The control machine has four states. IDLE accepts a request and looks it up. A hit goes straight to RESPOND. A miss whose victim is modified goes to WRITEBACK; any other miss goes to REFILL. WRITEBACK moves to REFILL when memory acknowledges, and REFILL moves to RESPOND on its acknowledge. RESPOND always returns to IDLE. A write miss allocates the line: the byte is fetched from memory and the write is merged in as the line is filled. Two counters record completed accesses and hits, so the hit ratio is `hit_count / acc_count`.

Top module: `bcache_top`

## Requirements
- R1: After reset every line is invalid and not modified, both counters read zero, and `cpu_ready` and `mem_req` are low.
- R2: An access selects line `addr[1:0]` and hits only when that line is valid (modified or shared) and its stored tag equals `{1'b0, addr[3:2]}`.
- R3: A hit raises `cpu_ready` together with `cpu_hit` one cycle after the request is accepted, with no memory transaction. A read hit returns the cached byte.
- R4: A read miss issues exactly one memory read of the requested address. It returns the fetched byte with `cpu_hit` low, and leaves the line shared (clean).
- R5: A write hit updates only the cache line and marks it modified. No memory write occurs, and a later read returns the written byte.
- R6: A write miss performs any required write-back, then one memory read of the address, then merges the write data into the line and marks it modified. The write data is returned on `cpu_rdata`.
- R7: A miss on a modified line first writes the old byte to address `{stored_tag[1:0], index}`. A miss on a clean or invalid line causes no memory write.
- R8: Every completed access increments `acc_count` by one in the cycle after `cpu_ready`. Hits also increment `hit_count`, and `hit_count` never exceeds `acc_count`.
- R9: `cpu_ready` is a single-cycle pulse that is never high while `mem_req` is high.
- R10: The upper bit of every stored tag is zero.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 4 | Byte address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Line data during the response cycle |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Access hit, valid with `cpu_ready` |
| mem_req | output | 1 | Backing memory request |
| mem_we | output | 1 | Memory write (write-back) when 1 |
| mem_addr | output | 4 | Memory byte address |
| mem_wdata | output | 8 | Write-back data |
| mem_rdata | input | 8 | Refill data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle memory completion |
| acc_count | output | 16 | Completed access count |
| hit_count | output | 16 | Hit count |

## Verification
The assertions check, on every cycle, the response-pulse rules, hit-only-with-ready, the stability of memory requests until they are acknowledged, the counter stepping and ordering, and the zero upper tag bit. Only the bench scenarios can show the outcome of each lookup. Those scenarios check hit or miss against a reference model and confirm that the right byte is returned. They also confirm that dirty victims reach memory at the address rebuilt from their tag and that clean evictions and write hits leave memory untouched. Write-allocate merging and the final memory image are checked the same way.

// File: rtl/bcache_pkg.sv
package bcache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITEBACK,
        ST_REFILL,
        ST_RESPOND
    } ctl_state_t;

    typedef enum logic [1:0] {
        LOP_NONE,
        LOP_FILL,
        LOP_STORE,
        LOP_CLEAN
    } line_op_t;
endpackage

// File: rtl/bcache_line_store.sv
module bcache_line_store
    import bcache_pkg::*;
#(
    parameter int LINES        = 4,
    parameter int IDX_W        = 2,
    parameter int STORED_TAG_W = 3,
    parameter int DATA_W       = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        rd_idx,
    input  line_op_t                op,
    input  logic [IDX_W-1:0]        op_idx,
    input  logic [STORED_TAG_W-1:0] op_tag,
    input  logic [DATA_W-1:0]       op_data,
    input  logic                    op_dirty,
    output logic                    rd_inv,
    output logic                    rd_mod,
    output logic                    rd_shr,
    output logic [STORED_TAG_W-1:0] rd_tag,
    output logic [DATA_W-1:0]       rd_data
);
    logic                    inv_q  [LINES];
    logic                    mod_q  [LINES];
    logic                    shr_q  [LINES];
    logic [STORED_TAG_W-1:0] tag_q  [LINES];
    logic [DATA_W-1:0]       data_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic sel;
        assign sel = (op_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                inv_q[g]  <= 1'b1;
                mod_q[g]  <= 1'b0;
                shr_q[g]  <= 1'b0;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (sel) begin
                unique case (op)
                    LOP_FILL: begin
                        inv_q[g]  <= 1'b0;
                        tag_q[g]  <= op_tag;
                        data_q[g] <= op_data;
                        mod_q[g]  <= op_dirty;
                        shr_q[g]  <= ~op_dirty;
                    end
                    LOP_STORE: begin
                        data_q[g] <= op_data;
                        mod_q[g]  <= 1'b1;
                        shr_q[g]  <= 1'b0;
                    end
                    LOP_CLEAN: begin
                        mod_q[g]  <= 1'b0;
                        shr_q[g]  <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_inv  = inv_q[rd_idx];
        rd_mod  = mod_q[rd_idx];
        rd_shr  = shr_q[rd_idx];
        rd_tag  = tag_q[rd_idx];
        rd_data = data_q[rd_idx];
    end
endmodule

// File: rtl/bcache_stats.sv
module bcache_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic             was_hit,
    output logic [CNT_W-1:0] acc_count,
    output logic [CNT_W-1:0] hit_count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_count <= '0;
            hit_count <= '0;
        end else if (done) begin
            acc_count <= acc_count + 1'b1;
            if (was_hit) hit_count <= hit_count + 1'b1;
        end
    end
endmodule

// File: rtl/bcache_miss_fsm.sv
module bcache_miss_fsm
    import bcache_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req,
    input  logic       lookup_hit,
    input  logic       victim_dirty,
    input  logic       mem_ack,
    output ctl_state_t state,
    output logic       accept,
    output logic       respond,
    output logic       mem_req,
    output logic       mem_we
);
    ctl_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (lookup_hit)        state_nx = ST_RESPOND;
                    else if (victim_dirty) state_nx = ST_WRITEBACK;
                    else                   state_nx = ST_REFILL;
                end
            end
            ST_WRITEBACK: if (mem_ack) state_nx = ST_REFILL;
            ST_REFILL:    if (mem_ack) state_nx = ST_RESPOND;
            ST_RESPOND:   state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        accept  = 1'b0;
        respond = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        unique case (state)
            ST_IDLE:      accept  = cpu_req;
            ST_WRITEBACK: begin mem_req = 1'b1; mem_we = 1'b1; end
            ST_REFILL:    mem_req = 1'b1;
            ST_RESPOND:   respond = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/bcache_top.sv
module bcache_top
    import bcache_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int LINES        = 4,
    parameter int DATA_W       = 8,
    parameter int STORED_TAG_W = 3,
    parameter int CNT_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              cpu_hit,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [CNT_W-1:0]  acc_count,
    output logic [CNT_W-1:0]  hit_count
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_state_t state;
    logic accept, respond;

    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic              hit_q;

    logic [IDX_W-1:0]        rd_idx;
    logic                    rd_inv, rd_mod, rd_shr;
    logic [STORED_TAG_W-1:0] rd_tag;
    logic [DATA_W-1:0]       rd_data;
    logic [STORED_TAG_W-1:0] tag_in_ext, tag_q_ext;
    logic                    lookup_hit, victim_dirty;

    line_op_t                op;
    logic [IDX_W-1:0]        op_idx;
    logic [DATA_W-1:0]       op_data;
    logic                    op_dirty;

    always_comb begin
        tag_in_ext = '0;
        tag_in_ext[TAG_W-1:0] = cpu_addr[ADDR_W-1:IDX_W];
        tag_q_ext = '0;
        tag_q_ext[TAG_W-1:0] = addr_q[ADDR_W-1:IDX_W];
    end

    assign rd_idx       = (state == ST_IDLE) ? cpu_addr[IDX_W-1:0] : addr_q[IDX_W-1:0];
    assign lookup_hit   = !rd_inv && (rd_mod || rd_shr) && (rd_tag == tag_in_ext);
    assign victim_dirty = !rd_inv && rd_mod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            hit_q   <= 1'b0;
        end else if (accept) begin
            addr_q  <= cpu_addr;
            we_q    <= cpu_we;
            wdata_q <= cpu_wdata;
            hit_q   <= lookup_hit;
        end
    end

    always_comb begin
        op       = LOP_NONE;
        op_idx   = addr_q[IDX_W-1:0];
        op_data  = wdata_q;
        op_dirty = 1'b0;
        if (accept && lookup_hit && cpu_we) begin
            op      = LOP_STORE;
            op_idx  = cpu_addr[IDX_W-1:0];
            op_data = cpu_wdata;
        end else if (state == ST_WRITEBACK && mem_ack) begin
            op = LOP_CLEAN;
        end else if (state == ST_REFILL && mem_ack) begin
            op       = LOP_FILL;
            op_data  = we_q ? wdata_q : mem_rdata;
            op_dirty = we_q;
        end
    end

    bcache_miss_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .lookup_hit   (lookup_hit),
        .victim_dirty (victim_dirty),
        .mem_ack      (mem_ack),
        .state        (state),
        .accept       (accept),
        .respond      (respond),
        .mem_req      (mem_req),
        .mem_we       (mem_we)
    );

    bcache_line_store #(
        .LINES        (LINES),
        .IDX_W        (IDX_W),
        .STORED_TAG_W (STORED_TAG_W),
        .DATA_W       (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .op       (op),
        .op_idx   (op_idx),
        .op_tag   (tag_q_ext),
        .op_data  (op_data),
        .op_dirty (op_dirty),
        .rd_inv   (rd_inv),
        .rd_mod   (rd_mod),
        .rd_shr   (rd_shr),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data)
    );

    bcache_stats #(.CNT_W(CNT_W)) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (respond),
        .was_hit   (hit_q),
        .acc_count (acc_count),
        .hit_count (hit_count)
    );

    assign mem_addr  = (state == ST_WRITEBACK) ? {rd_tag[TAG_W-1:0], addr_q[IDX_W-1:0]} : addr_q;
    assign mem_wdata = rd_data;
    assign cpu_ready = respond;
    assign cpu_hit   = respond && hit_q;
    assign cpu_rdata = respond ? rd_data : '0;
endmodule

// File: rtl/bcache_chk.sv
module bcache_chk #(
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 8,
    parameter int STORED_TAG_W = 3,
    parameter int TAG_W        = 2,
    parameter int CNT_W        = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cpu_ready,
    input logic                    cpu_hit,
    input logic                    mem_req,
    input logic                    mem_we,
    input logic                    mem_ack,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [DATA_W-1:0]       mem_wdata,
    input logic [CNT_W-1:0]        acc_count,
    input logic [CNT_W-1:0]        hit_count,
    input logic [STORED_TAG_W-1:0] rd_tag
);
    // R9
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ready && mem_req));
    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);
    // R3
    hit_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> cpu_ready);
    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
    // R8
    acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> (acc_count == CNT_W'($past(acc_count) + 1'b1)));
    // R8
    acc_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_ready |=> $stable(acc_count));
    // R8
    hits_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count <= acc_count);
    // R10
    tag_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_tag[STORED_TAG_W-1:TAG_W] == '0);
endmodule

bind bcache_top bcache_chk #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .STORED_TAG_W (STORED_TAG_W),
    .TAG_W        (TAG_W),
    .CNT_W        (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_ready (cpu_ready),
    .cpu_hit   (cpu_hit),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .acc_count (acc_count),
    .hit_count (hit_count),
    .rd_tag    (rd_tag)
);

// File: tb/bcache_top_bench.sv
module bcache_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0;
    logic       cpu_we = 1'b0;
    logic [3:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_ready, cpu_hit;
    logic       mem_req, mem_we;
    logic [3:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = '0;
    logic       mem_ack = 1'b0;
    logic [15:0] acc_count, hit_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcache_top u_bcache_top (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .acc_count(acc_count), .hit_count(hit_count)
    );

    // backing memory model
    logic [7:0] mem [16];
    int         lat_cnt = 0;
    int         wr_cnt = 0;
    int         rd_cnt = 0;
    logic [3:0] last_wr_addr = '0;
    logic [7:0] last_wr_data = '0;

    initial for (int i = 0; i < 16; i++) mem[i] = 8'(8'h30 + i * 7);

    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
            lat_cnt <= 0;
        end else if (mem_req) begin
            if (lat_cnt == MEM_LAT) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    wr_cnt        <= wr_cnt + 1;
                    last_wr_addr  <= mem_addr;
                    last_wr_data  <= mem_wdata;
                end else begin
                    mem_rdata <= mem[mem_addr];
                    rd_cnt    <= rd_cnt + 1;
                end
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    // reference model
    bit         ref_valid [4];
    bit         ref_dirty [4];
    int         ref_tag   [4];
    logic [7:0] ref_data  [4];
    logic [7:0] exp_mem   [16];
    int         exp_acc = 0;
    int         exp_hits = 0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_hit(input logic [3:0] a);
        return ref_valid[a % 4] && (ref_tag[a % 4] == int'(a / 4));
    endfunction

    task automatic access(input bit we, input logic [3:0] a, input logic [7:0] d);
        int idx, tg, cycles, w0, r0;
        bit ehit, ewb;
        logic [3:0] wb_addr;
        logic [7:0] wb_data, erd;
        string rq;
        idx  = int'(a % 4);
        tg   = int'(a / 4);
        ehit = model_hit(a);
        ewb  = !ehit && ref_valid[idx] && ref_dirty[idx];
        wb_addr = 4'(ref_tag[idx] * 4 + idx);
        wb_data = ref_data[idx];
        if (ewb) exp_mem[wb_addr] = wb_data;
        if (!ehit) begin
            ref_valid[idx] = 1'b1;
            ref_tag[idx]   = tg;
            ref_data[idx]  = exp_mem[a];
            ref_dirty[idx] = 1'b0;
        end
        if (we) begin
            ref_data[idx]  = d;
            ref_dirty[idx] = 1'b1;
        end
        erd = ref_data[idx];
        exp_acc++;
        if (ehit) exp_hits++;
        if (ehit) rq = we ? "R5" : "R3";
        else      rq = we ? "R6" : "R4";

        w0 = wr_cnt;
        r0 = rd_cnt;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (!cpu_ready && cycles < 200);
        check(cycles < 200, rq, "response timeout", cycles, 200);
        check(cpu_hit == ehit, "R2", "hit flag", int'(cpu_hit), int'(ehit));
        check(cpu_rdata == erd, rq, "returned data", int'(cpu_rdata), int'(erd));
        cpu_req = 1'b0;
        check((wr_cnt - w0) == (ewb ? 1 : 0), "R7", "memory writes", wr_cnt - w0, ewb ? 1 : 0);
        if (ewb) begin
            check(last_wr_addr == wb_addr, "R7", "write-back address", int'(last_wr_addr), int'(wb_addr));
            check(last_wr_data == wb_data, "R7", "write-back data", int'(last_wr_data), int'(wb_data));
        end
        check((rd_cnt - r0) == (ehit ? 0 : 1), rq, "memory reads", rd_cnt - r0, ehit ? 0 : 1);
        if (ehit) check(cycles == 1, "R3", "hit latency", cycles, 1);
        else      check(cycles > 1, "R9", "miss latency", cycles, 2);
    endtask

    task automatic check_counters(input string tag);
        @(negedge clk);
        check(acc_count == 16'(exp_acc), "R8", {tag, " access count"}, int'(acc_count), exp_acc);
        check(hit_count == 16'(exp_hits), "R8", {tag, " hit count"}, int'(hit_count), exp_hits);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            ref_valid[i] = 1'b0; ref_dirty[i] = 1'b0; ref_tag[i] = 0; ref_data[i] = '0;
        end
        for (int i = 0; i < 16; i++) exp_mem[i] = 8'(8'h30 + i * 7);
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        check(cpu_ready == 1'b0, "R1", "ready after reset", int'(cpu_ready), 0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", int'(mem_req), 0);
        check(acc_count == 16'd0, "R1", "access count after reset", int'(acc_count), 0);
        check(hit_count == 16'd0, "R1", "hit count after reset", int'(hit_count), 0);
        rst_n = 1'b1;

        // R1: every line starts invalid, so the first touch of each misses
        for (int i = 0; i < 4; i++) access(1'b0, 4'(i), 8'h00);
        access(1'b0, 4'd0, 8'h00);          // R3 read hit
        access(1'b0, 4'd4, 8'h00);          // R7 clean eviction
        access(1'b1, 4'd4, 8'h5A);          // R5 write hit
        access(1'b0, 4'd4, 8'h00);          // R5 read back
        access(1'b0, 4'd8, 8'h00);          // R7 dirty eviction of address 4
        access(1'b1, 4'd13, 8'hC3);         // R6 write miss, clean victim
        access(1'b1, 4'd1, 8'h77);          // R6 write miss, dirty victim 13
        access(1'b1, 4'd1, 8'h78);          // R5 write hit
        access(1'b0, 4'd15, 8'h00);         // R4 read miss
        access(1'b1, 4'd11, 8'hEE);         // R6 dirty victim afterwards
        access(1'b0, 4'd3, 8'h00);          // R7 dirty eviction of 11
        check_counters("directed");

        for (int n = 0; n < 300; n++) begin
            logic [3:0] a;
            logic [7:0] d;
            bit         w;
            a = 4'($urandom % 16);
            d = 8'($urandom);
            w = ($urandom % 3) == 0;
            access(w, a, d);
        end
        check_counters("random");

        // R7: memory image matches the write-back history
        for (int i = 0; i < 16; i++)
            check(mem[i] == exp_mem[i], "R7", "memory image", int'(mem[i]), int'(exp_mem[i]));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule